// File: doc/BRIEF.md
# Strobed Parallel Input Port with Interrupt Flag

This block captures a seven-bit code from a set of input pins when an external strobe line makes its active transition. The strobe is first brought into the clock domain through a short flip-flop chain. Each active transition then latches the code and sets a status flag. When the port is armed, the flag drives an interrupt request.

Software talks to the port over a simple register bus with separate read and write strobes. One address holds the combined control and status register and the other holds the latched code. The flag cannot be written. It is acknowledged by a two-step access: first a status read that sees the flag set, then a read of the latched code. A new strobe edge that lands between those two reads keeps the flag set, so no key press is lost.

Top module: `strobe_port`

## Requirements
- R1: After reset the control/status register (address 0) reads 0x00: flag clear, interrupt disarmed, falling strobe edge selected; the data register (address 1) reads 0x00 and the interrupt request is low.
- R2: With the edge-select bit (bit 1 of address 0) at 0, a falling transition on the strobe sets the flag (bit 7 of address 0) and latches the data pins into the data register.
- R3: With the edge-select bit at 1, a rising transition on the strobe sets the flag and latches the data pins. The transition of the other direction leaves the flag unchanged.
- R4: The interrupt request is high exactly when the flag is set and the arm bit (bit 6 of address 0) is 1.
- R5: A read of address 0 that returns the flag set, followed later by a read of address 1, clears the flag.
- R6: A read of address 1 that is not preceded by a status read seeing the flag set leaves the flag set.
- R7: If an active strobe edge occurs after the qualifying status read and before the data read, the flag stays set after that data read.
- R8: Writing 0x42 to address 0 selects the rising edge and arms the interrupt, and address 0 then reads back 0x42 while the flag is clear. Writes never change bit 7.
- R9: The data register reads its latched code in bits 6..0 with bit 7 at 0. It holds its value while the data pins change with no active strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| strobeIn | input | 1 | Asynchronous strobe line |
| dataIn | input | 7 | Code pins, latched on the active strobe edge |
| busRd | input | 1 | Register read strobe, one cycle per read |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 2 | Register address: 0 control/status, 1 data |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for the addressed register |
| irqOut | output | 1 | Interrupt request |

## Verification
The bench checks the acknowledge sequence from both sides. A data read with no earlier status read must not clear the flag; a design that clears on any data read would lose an unread code. It also sends a new strobe between the two halves of the acknowledge; a design that does not cancel the pending clear would drop the second event. It applies strobe transitions of the inactive direction in both edge modes, which catches a swapped edge decoder. It writes a 1 into the flag bit, which catches a flag that software can write.

// File: rtl/strobe_port_pkg.sv
package strobe_port_pkg;
  // Bit positions in the control/status register; software relies on them.
  localparam int FLAG_BIT = 7;
  localparam int ARM_BIT  = 6;
  localparam int EDGE_BIT = 1;

  typedef struct packed {
    logic capture;  // latch the data pins this cycle
    logic flag;     // current status flag
  } portCtl_t;
endpackage

// File: rtl/strobe_port_dp.sv
module strobe_port_dp
  import strobe_port_pkg::*;
#(
  parameter int DATA_W      = 7,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 2,
  parameter int REG_W       = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 0,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strobeIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWdata,
  input  portCtl_t          ctl,
  output logic              edgeHit,
  output logic              armQ,
  output logic [DATA_W-1:0] dataQ,
  output logic [REG_W-1:0]  busRdata
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic strobeS, prevQ, edgeSelQ, riseHit, fallHit;

  genvar g;
  for (g = 0; g < SYNC_STAGES; g++) begin : gSync
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ[g] <= 1'b0;
        else       syncQ[g] <= strobeIn;
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ[g] <= 1'b0;
        else       syncQ[g] <= syncQ[g-1];
    end
  end

  assign strobeS = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= strobeS;

  assign riseHit = strobeS & ~prevQ;
  assign fallHit = ~strobeS & prevQ;
  assign edgeHit = edgeSelQ ? riseHit : fallHit;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      armQ     <= 1'b0;
      edgeSelQ <= 1'b0;
    end else if (busWr && busAddr == CTRL_ADDR) begin
      armQ     <= busWdata[ARM_BIT];
      edgeSelQ <= busWdata[EDGE_BIT];
    end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)            dataQ <= '0;
    else if (ctl.capture) dataQ <= dataIn;

  always_comb begin
    busRdata = '0;
    if (busAddr == CTRL_ADDR) begin
      busRdata[FLAG_BIT] = ctl.flag;
      busRdata[ARM_BIT]  = armQ;
      busRdata[EDGE_BIT] = edgeSelQ;
    end else if (busAddr == DATA_ADDR) begin
      busRdata[DATA_W-1:0] = dataQ;
    end
  end
endmodule

// File: rtl/strobe_port_ctrl.sv
module strobe_port_ctrl
  import strobe_port_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     edgeHit,
  input  logic     statusRd,
  input  logic     dataRd,
  output portCtl_t ctl,
  output logic     pendQ
);
  logic flagQ;

  // A qualifying status read arms the clear; the data read then fires it.
  // A fresh edge always wins and cancels any armed clear.
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      flagQ <= 1'b0;
      pendQ <= 1'b0;
    end else if (edgeHit) begin
      flagQ <= 1'b1;
      pendQ <= 1'b0;
    end else if (dataRd && pendQ) begin
      flagQ <= 1'b0;
      pendQ <= 1'b0;
    end else if (statusRd) begin
      pendQ <= flagQ;
    end

  assign ctl.capture = edgeHit;
  assign ctl.flag    = flagQ;
endmodule

// File: rtl/strobe_port.sv
module strobe_port
  import strobe_port_pkg::*;
#(
  parameter int DATA_W      = 7,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 2,
  parameter int REG_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strobeIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWdata,
  output logic [REG_W-1:0]  busRdata,
  output logic              irqOut
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(1);

  portCtl_t          ctl;
  logic              edgeHit, armQ, pendQ, flagNow, statusRd, dataRd;
  logic [DATA_W-1:0] dataQ;

  assign statusRd = busRd && busAddr == CTRL_ADDR;
  assign dataRd   = busRd && busAddr == DATA_ADDR;
  assign flagNow  = ctl.flag;

  strobe_port_dp #(
    .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES), .ADDR_W(ADDR_W), .REG_W(REG_W),
    .CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobeIn(strobeIn), .dataIn(dataIn),
    .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata), .ctl(ctl),
    .edgeHit(edgeHit), .armQ(armQ), .dataQ(dataQ), .busRdata(busRdata)
  );

  strobe_port_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .edgeHit(edgeHit), .statusRd(statusRd),
    .dataRd(dataRd), .ctl(ctl), .pendQ(pendQ)
  );

  assign irqOut = flagNow & armQ;
endmodule

// File: rtl/strobe_port_chk.sv
module strobe_port_chk #(
  parameter int DATA_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              edgeHit,
  input logic              flag,
  input logic              pend,
  input logic              dataRd,
  input logic [DATA_W-1:0] dataQ,
  input logic              irqOut
);
  // R2 R3
  edge_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    edgeHit |=> flag);

  // R5
  pair_clears_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && pend && !edgeHit) |=> !flag);

  // R6
  flag_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flag && !(dataRd && pend)) |=> flag);

  // R7
  edge_cancels_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    edgeHit |=> !pend);

  // R9
  data_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    !edgeHit |=> $stable(dataQ));

  // R4
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> flag);

  // R8
  flag_rise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flag) |-> $past(edgeHit));
endmodule

bind strobe_port strobe_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .edgeHit(edgeHit), .flag(flagNow), .pend(pendQ),
  .dataRd(dataRd), .dataQ(dataQ), .irqOut(irqOut)
);

// File: tb/strobe_port_bench.sv
`timescale 1ns/1ps
module strobe_port_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       strobeIn = 1'b1;
  logic [6:0] dataIn = '0;
  logic       busRd = 1'b0, busWr = 1'b0;
  logic [1:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       irqOut;

  int nRun = 0, nFail = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sbQ[$];

  always #2.5 clk = ~clk;

  strobe_port u_strobe_port (
    .clk(clk), .rstN(rstN), .strobeIn(strobeIn), .dataIn(dataIn),
    .busRd(busRd), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .irqOut(irqOut)
  );

  // Monitor: compares every read against the next expected item.
  always @(negedge clk) begin
    if (busRd) begin
      nRun++;
      if (sbQ.size() == 0) begin
        nFail++;
        $display("FAIL scoreboard empty: read got %02h, expected an item", busRdata);
      end else begin
        item_t it;
        it = sbQ.pop_front();
        if (busRdata !== it.exp) begin
          nFail++;
          $display("FAIL %s: read %02h expected %02h", it.tag, busRdata, it.exp);
        end
      end
    end
  end

  task automatic busRead(input logic [1:0] a, input logic [7:0] e, input string tag);
    @(posedge clk); #1;
    busRd = 1'b1; busAddr = a;
    sbQ.push_back('{e, tag});
    @(posedge clk); #1;
    busRd = 1'b0;
  endtask

  task automatic busWrite(input logic [7:0] d);
    @(posedge clk); #1;
    busWr = 1'b1; busAddr = 2'd0; busWdata = d;
    @(posedge clk); #1;
    busWr = 1'b0;
  endtask

  task automatic setStrobe(input logic v);
    @(posedge clk); #1;
    strobeIn = v;
    repeat (5) @(posedge clk);
  endtask

  task automatic checkIrq(input logic e, input string tag);
    @(negedge clk);
    nRun++;
    if (irqOut !== e) begin
      nFail++;
      $display("FAIL %s: irq %0b expected %0b", tag, irqOut, e);
    end
  endtask

  initial begin
    #(20000 * 5);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    repeat (4) @(posedge clk);
    // R1 reset state
    busRead(2'd0, 8'h00, "R1");
    busRead(2'd1, 8'h00, "R1");
    checkIrq(1'b0, "R1");

    // R2 falling edge in default mode
    dataIn = 7'h35;
    setStrobe(1'b0);
    busRead(2'd0, 8'h80, "R2");
    checkIrq(1'b0, "R4");
    busRead(2'd1, 8'h35, "R2");
    busRead(2'd0, 8'h00, "R5");

    // R3 rising edge ignored in falling mode
    setStrobe(1'b1);
    busRead(2'd0, 8'h00, "R3");

    // R8 configuration write, flag bit not writable
    busWrite(8'h42);
    busRead(2'd0, 8'h42, "R8");
    busWrite(8'hC2);
    busRead(2'd0, 8'h42, "R8");

    // R3 rising mode: falling ignored, rising sets
    dataIn = 7'h5A;
    setStrobe(1'b0);
    busRead(2'd0, 8'h42, "R3");
    checkIrq(1'b0, "R4");
    setStrobe(1'b1);
    checkIrq(1'b1, "R4");
    // R6 data read without a qualifying status read
    busRead(2'd1, 8'h5A, "R3");
    busRead(2'd0, 8'hC2, "R6");
    // R9 pins change without an edge
    dataIn = 7'h11;
    repeat (3) @(posedge clk);
    busRead(2'd1, 8'h5A, "R9");
    busRead(2'd0, 8'h42, "R5");
    checkIrq(1'b0, "R4");

    // R7 edge between status read and data read
    dataIn = 7'h22;
    setStrobe(1'b0);
    setStrobe(1'b1);
    busRead(2'd0, 8'hC2, "R7");
    dataIn = 7'h33;
    setStrobe(1'b0);
    setStrobe(1'b1);
    busRead(2'd1, 8'h33, "R7");
    busRead(2'd0, 8'hC2, "R7");
    busRead(2'd1, 8'h33, "R5");
    busRead(2'd0, 8'h42, "R5");

    // R4 disarmed: flag set but no request
    busWrite(8'h02);
    setStrobe(1'b0);
    setStrobe(1'b1);
    busRead(2'd0, 8'h82, "R4");
    checkIrq(1'b0, "R4");

    repeat (3) @(posedge clk);
    if (sbQ.size() != 0) begin
      nRun++; nFail++;
      $display("FAIL scoreboard: %0d items left, expected 0", sbQ.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule